// File: doc/BRIEF.md
# Receive Buffer Ring DMA Controller

This block is the device side of a single receive descriptor ring that lives in host memory. Software programs a ring base, the address of a small status word, a configuration word and a producer index. Each incoming frame takes the next free descriptor and is placed in the buffer that descriptor points to. When a buffer is closed, the block posts the index of that descriptor to the status word and can raise an interrupt. Descriptor reads, payload writes and the status write appear only as request strobes that carry addresses. A downstream bus master turns these requests into memory traffic.

Buffers are closed at the end of a frame. A buffer is also closed when the frame stalls for longer than a programmable number of 32 µs ticks. The channel has three modes: run, stop after the current frame, and stop at once. An idle flag shows when a stopped channel has no buffer open. Software hands over free descriptors in groups of eight. The ring counts as full when the consumer index equals the producer index, so one slot always stays unused.

Top module: `rbr_dma`

## Requirements
- R1: After a synchronous reset, all strobes are low, `rd_index` is 0, `overflow` is 0 and `chan_idle` is 1.
- R2: The ring holds 2^N entries, with N taken from `cfg_word[23:20]`. N is clamped to the range 5..12. `rd_index` advances by one for each closed buffer and wraps to 0 at the end of the ring.
- R3: Opening a buffer pulses `buf_open`. At the same time `buf_desc_addr` = `ring_base`·256 + 4·index, which is the byte address of the one-word descriptor whose bits 27:0 hold buffer address bits 35:8.
- R4: Each accepted frame beat pulses `pay_wr`, with byte offsets 0, 4, 8, … The buffer size comes from `cfg_word[17:16]`: 00 = 4 KiB, 01 = 8 KiB, 10 = 12 KiB, 11 = 16 KiB. Beats past the buffer size produce no write.
- R5: The effective producer index is `wr_index` rounded down to a multiple of 8, taken modulo the ring size. If a frame starts in run mode while the consumer index equals this value, the frame is dropped and the sticky `overflow` flag is set.
- R6: Closing a buffer pulses `stat_wr`. `stat_data[11:0]` holds the filled descriptor index and the upper bits are 0. `stat_addr` = `stat_base`·16.
- R7: `cfg_word[11:4]` gives a timeout T in ticks. When a buffer is open and T ticks pass with no beat, the buffer is closed like a normal close, and the rest of that frame is discarded. T = 0 disables the timeout.
- R8: `irq` pulses together with `stat_wr` only when `cfg_word[13:12]` = 01. Any other value gives no interrupt.
- R9: The mode is `cfg_word[31:30]`. In 10 (run), new frames are accepted. In 01, an open frame completes normally but no new frame starts. In 00 or 11, an open frame is abandoned at once with no status write and no index advance, and its remaining beats are discarded.
- R10: One cycle after the change, `chan_idle` is 1 exactly when no buffer is open and the mode is not run.
- R11: Frames that arrive while the mode is not run are dropped and do not set `overflow`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_word | input | 32 | Channel configuration word |
| ring_base | input | 28 | Ring base address bits 35:8 |
| stat_base | input | 32 | Status word address bits 35:4 |
| wr_index | input | 12 | Producer index written by software |
| tick_32us | input | 1 | One-cycle timebase pulse every 32 µs |
| frm_valid | input | 1 | Frame beat present |
| frm_last | input | 1 | Beat is the last of its frame |
| buf_open | output | 1 | Descriptor fetch request |
| buf_desc_addr | output | 36 | Byte address of the descriptor |
| pay_wr | output | 1 | Payload word write request |
| pay_off | output | 14 | Byte offset of the write within the buffer |
| stat_wr | output | 1 | Status write request |
| stat_addr | output | 36 | Byte address of the status word |
| stat_data | output | 32 | Status word value |
| irq | output | 1 | Interrupt pulse to host |
| chan_idle | output | 1 | Channel stopped with no buffer open |
| overflow | output | 1 | Sticky: frame lost to a full ring |
| rd_index | output | 12 | Next descriptor index to fill |

## Verification
A behavioural model in the bench predicts every output on every cycle. Back-to-back frames of varied length fill a 256-entry ring up to its producer index, which separates correct full detection and rounding of the index from off-by-one errors. A frame longer than a 4 KiB buffer checks truncation. A stalled frame checks the timeout close against a normal close. Mode changes in the middle of a frame separate a graceful stop from an abort. A clamped 32-entry ring driven across its end exercises index wrap and overflow in the same run.

// File: rtl/rbr_pkg.sv
package rbr_pkg;

  typedef enum logic [1:0] {
    MODE_OFF = 2'b00,
    MODE_EOF = 2'b01,
    MODE_RUN = 2'b10,
    MODE_RSV = 2'b11
  } rbr_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_DROP = 2'd2
  } rbr_state_e;

  typedef struct packed {
    rbr_mode_e  mode;
    logic [3:0] ring_log;
    logic [1:0] buf_sel;
    logic [1:0] irq_dst;
    logic [7:0] tmo;
  } rbr_cfg_t;

  localparam int CFG_MODE_LSB = 30;
  localparam int CFG_LOG_LSB  = 20;
  localparam int CFG_BUF_LSB  = 16;
  localparam int CFG_IRQ_LSB  = 12;
  localparam int CFG_TMO_LSB  = 4;

  function automatic rbr_cfg_t rbr_decode(input logic [31:0] w);
    rbr_cfg_t c;
    c.mode     = rbr_mode_e'(w[CFG_MODE_LSB +: 2]);
    c.ring_log = w[CFG_LOG_LSB +: 4];
    c.buf_sel  = w[CFG_BUF_LSB +: 2];
    c.irq_dst  = w[CFG_IRQ_LSB +: 2];
    c.tmo      = w[CFG_TMO_LSB +: 8];
    return c;
  endfunction

endpackage

// File: rtl/rbr_ring_ctl.sv
module rbr_ring_ctl #(
  parameter int IDX_W   = 12,
  parameter int LOG_MIN = 5,
  parameter int LOG_MAX = 12,
  parameter int STEP    = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [3:0]       ring_log,
  input  logic [IDX_W-1:0] wr_index,
  input  logic             adv,
  output logic [IDX_W-1:0] rd_q,
  output logic [IDX_W-1:0] rd_cur,
  output logic             full
);
  localparam logic [IDX_W-1:0] STEP_MASK = IDX_W'(STEP - 1);

  logic [3:0]       lg;
  logic [IDX_W-1:0] mask;
  logic [IDX_W-1:0] wr_eff;

  always_comb begin
    lg = ring_log;
    if (lg < 4'(LOG_MIN)) lg = 4'(LOG_MIN);
    if (lg > 4'(LOG_MAX)) lg = 4'(LOG_MAX);
    mask   = (IDX_W'(1) << lg) - IDX_W'(1);
    wr_eff = wr_index & mask & ~STEP_MASK;
    rd_cur = rd_q & mask;
    full   = ((wr_eff - rd_cur) & mask) == '0;
  end

  always_ff @(posedge clk) begin
    if (rst)      rd_q <= '0;
    else if (adv) rd_q <= (rd_cur + IDX_W'(1)) & mask;
  end
endmodule

// File: rtl/rbr_tmo.sv
module rbr_tmo #(
  parameter int TMO_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             kick,
  input  logic             tick,
  input  logic [TMO_W-1:0] limit,
  output logic             expire
);
  logic [TMO_W-1:0] cnt;
  logic [TMO_W:0]   nxt;

  always_comb begin
    nxt    = {1'b0, cnt} + (TMO_W+1)'(1);
    expire = run && !kick && tick && (limit != '0) && (nxt >= {1'b0, limit});
  end

  always_ff @(posedge clk) begin
    if (rst || !run || kick)   cnt <= '0;
    else if (tick && !expire)  cnt <= nxt[TMO_W-1:0];
  end
endmodule

// File: rtl/rbr_fill.sv
module rbr_fill
  import rbr_pkg::*;
#(
  parameter int OFF_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  rbr_mode_e        mode,
  input  logic [OFF_W-1:0] buf_bytes,
  input  logic             frm_valid,
  input  logic             frm_last,
  input  logic             full,
  input  logic             expire,
  output rbr_state_e       st_q,
  output rbr_state_e       st_d,
  output logic             do_open,
  output logic             do_write,
  output logic             do_close,
  output logic             do_ovf,
  output logic [OFF_W-1:0] wr_off
);
  localparam logic [OFF_W-1:0] WORD = OFF_W'(4);

  logic [OFF_W-1:0] off_q;
  logic [OFF_W-1:0] off_d;
  logic             halt;

  always_comb begin
    halt     = (mode == MODE_OFF) || (mode == MODE_RSV);
    st_d     = st_q;
    off_d    = off_q;
    do_open  = 1'b0;
    do_write = 1'b0;
    do_close = 1'b0;
    do_ovf   = 1'b0;
    wr_off   = off_q;
    case (st_q)
      ST_IDLE: begin
        if (frm_valid) begin
          if (mode == MODE_RUN && !full) begin
            do_open  = 1'b1;
            do_write = 1'b1;
            wr_off   = '0;
            off_d    = WORD;
            if (frm_last) do_close = 1'b1;
            else          st_d     = ST_FILL;
          end else begin
            do_ovf = (mode == MODE_RUN);
            if (!frm_last) st_d = ST_DROP;
          end
        end
      end
      ST_FILL: begin
        if (halt) begin
          st_d = (frm_valid && frm_last) ? ST_IDLE : ST_DROP;
        end else if (frm_valid) begin
          if (off_q < buf_bytes) begin
            do_write = 1'b1;
            off_d    = off_q + WORD;
          end
          if (frm_last) begin
            do_close = 1'b1;
            st_d     = ST_IDLE;
          end
        end else if (expire) begin
          do_close = 1'b1;
          st_d     = ST_DROP;
        end
      end
      default: begin
        if (frm_valid && frm_last) st_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_IDLE;
      off_q <= '0;
    end else begin
      st_q  <= st_d;
      off_q <= off_d;
    end
  end
endmodule

// File: rtl/rbr_dma.sv
module rbr_dma
  import rbr_pkg::*;
#(
  parameter int IDX_W        = 12,
  parameter int LOG_MIN      = 5,
  parameter int LOG_MAX      = 12,
  parameter int STEP         = 8,
  parameter int BASE_W       = 28,
  parameter int SBASE_W      = 32,
  parameter int TMO_W        = 8,
  parameter int BUF_UNIT_LOG = 12,
  parameter int OFF_W        = 15,
  localparam int DADDR_W     = BASE_W + 8,
  localparam int SADDR_W     = SBASE_W + 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [31:0]        cfg_word,
  input  logic [BASE_W-1:0]  ring_base,
  input  logic [SBASE_W-1:0] stat_base,
  input  logic [IDX_W-1:0]   wr_index,
  input  logic               tick_32us,
  input  logic               frm_valid,
  input  logic               frm_last,
  output logic               buf_open,
  output logic [DADDR_W-1:0] buf_desc_addr,
  output logic               pay_wr,
  output logic [OFF_W-2:0]   pay_off,
  output logic               stat_wr,
  output logic [SADDR_W-1:0] stat_addr,
  output logic [31:0]        stat_data,
  output logic               irq,
  output logic               chan_idle,
  output logic               overflow,
  output logic [IDX_W-1:0]   rd_index
);
  rbr_cfg_t         cfg;
  logic [OFF_W-1:0] buf_bytes;
  logic [IDX_W-1:0] rd_cur;
  logic             full, expire;
  logic             do_open, do_write, do_close, do_ovf;
  logic [OFF_W-1:0] wr_off;
  rbr_state_e       st_q, st_d;

  always_comb begin
    cfg       = rbr_decode(cfg_word);
    buf_bytes = OFF_W'({1'b0, cfg.buf_sel} + 3'd1) << BUF_UNIT_LOG;
  end

  rbr_ring_ctl #(
    .IDX_W(IDX_W), .LOG_MIN(LOG_MIN), .LOG_MAX(LOG_MAX), .STEP(STEP)
  ) u_ring (
    .clk(clk), .rst(rst), .ring_log(cfg.ring_log), .wr_index(wr_index),
    .adv(do_close), .rd_q(rd_index), .rd_cur(rd_cur), .full(full)
  );

  rbr_tmo #(.TMO_W(TMO_W)) u_tmo (
    .clk(clk), .rst(rst), .run(st_q == ST_FILL), .kick(frm_valid),
    .tick(tick_32us), .limit(TMO_W'(cfg.tmo)), .expire(expire)
  );

  rbr_fill #(.OFF_W(OFF_W)) u_fill (
    .clk(clk), .rst(rst), .mode(cfg.mode), .buf_bytes(buf_bytes),
    .frm_valid(frm_valid), .frm_last(frm_last), .full(full), .expire(expire),
    .st_q(st_q), .st_d(st_d), .do_open(do_open), .do_write(do_write),
    .do_close(do_close), .do_ovf(do_ovf), .wr_off(wr_off)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      buf_open      <= 1'b0;
      buf_desc_addr <= '0;
      pay_wr        <= 1'b0;
      pay_off       <= '0;
      stat_wr       <= 1'b0;
      stat_addr     <= '0;
      stat_data     <= '0;
      irq           <= 1'b0;
      chan_idle     <= 1'b1;
      overflow      <= 1'b0;
    end else begin
      buf_open      <= do_open;
      buf_desc_addr <= {ring_base, 8'h00} + DADDR_W'({rd_cur, 2'b00});
      pay_wr        <= do_write;
      pay_off       <= wr_off[OFF_W-2:0];
      stat_wr       <= do_close;
      stat_addr     <= {stat_base, 4'h0};
      stat_data     <= 32'(rd_cur);
      irq           <= do_close && (cfg.irq_dst == 2'b01);
      chan_idle     <= (st_d != ST_FILL) && (cfg.mode != MODE_RUN);
      overflow      <= overflow | do_ovf;
    end
  end
endmodule

// File: rtl/rbr_dma_chk.sv
module rbr_dma_chk #(
  parameter int IDX_W = 12,
  parameter int OFF_W = 15
) (
  input logic             clk,
  input logic             rst,
  input logic             buf_open,
  input logic             pay_wr,
  input logic [OFF_W-2:0] pay_off,
  input logic             stat_wr,
  input logic [31:0]      stat_data,
  input logic             irq,
  input logic             overflow,
  input logic [IDX_W-1:0] rd_index
);
  AST_IRQ_WITH_STAT: assert property (@(posedge clk) disable iff (rst) irq |-> stat_wr); // R8
  AST_OPEN_AT_ZERO: assert property (@(posedge clk) disable iff (rst) buf_open |-> (pay_wr && pay_off == '0)); // R3
  AST_STAT_HIGH_ZERO: assert property (@(posedge clk) disable iff (rst) stat_wr |-> (stat_data[31:IDX_W] == '0)); // R6
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst) overflow |=> overflow); // R5
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst) !stat_wr |-> (rd_index == $past(rd_index))); // R2
  AST_RD_ADVANCE: assert property (@(posedge clk) disable iff (rst) stat_wr |-> (rd_index != $past(rd_index))); // R2
endmodule

bind rbr_dma rbr_dma_chk #(.IDX_W(IDX_W), .OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst(rst), .buf_open(buf_open), .pay_wr(pay_wr), .pay_off(pay_off),
  .stat_wr(stat_wr), .stat_data(stat_data), .irq(irq), .overflow(overflow),
  .rd_index(rd_index)
);

// File: tb/rbr_dma_test.sv
module rbr_dma_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] cfg_word = 32'h0;
  logic [27:0] ring_base = 28'h0ABCDE1;
  logic [31:0] stat_base = 32'h0123_4567;
  logic [11:0] wr_index = 12'h0;
  logic        tick_32us = 1'b0;
  logic        frm_valid = 1'b0;
  logic        frm_last = 1'b0;
  logic        buf_open, pay_wr, stat_wr, irq, chan_idle, overflow;
  logic [35:0] buf_desc_addr, stat_addr;
  logic [13:0] pay_off;
  logic [31:0] stat_data;
  logic [11:0] rd_index;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int tcnt = 0;

  always #4 clk = ~clk;

  rbr_dma uut (
    .clk(clk), .rst(rst), .cfg_word(cfg_word), .ring_base(ring_base),
    .stat_base(stat_base), .wr_index(wr_index), .tick_32us(tick_32us),
    .frm_valid(frm_valid), .frm_last(frm_last), .buf_open(buf_open),
    .buf_desc_addr(buf_desc_addr), .pay_wr(pay_wr), .pay_off(pay_off),
    .stat_wr(stat_wr), .stat_addr(stat_addr), .stat_data(stat_data),
    .irq(irq), .chan_idle(chan_idle), .overflow(overflow), .rd_index(rd_index)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int mode, input int lg, input int bsel, input int idst, input int tmo);
    return {2'(mode), 6'h0, 4'(lg), 2'h0, 2'(bsel), 2'h0, 2'(idst), 8'(tmo), 4'h0};
  endfunction

  // Behavioural reference model
  int     m_st = 0, m_rd = 0, m_off = 0, m_cnt = 0;
  bit     e_open = 0, e_pw = 0, e_sw = 0, e_irq = 0, e_idle = 1, e_ovf = 0;
  longint e_desc = 0, e_po = 0, e_sd = 0, e_sa = 0;

  always @(posedge clk) begin
    int mode, lg, sz, bb, tmo, rdm, weff, nst, ncnt;
    bit full, ex, cls, hirq;
    if (rst) begin
      m_st = 0; m_rd = 0; m_off = 0; m_cnt = 0;
      e_open = 0; e_pw = 0; e_sw = 0; e_irq = 0; e_idle = 1; e_ovf = 0;
    end else begin
      mode = int'(cfg_word[31:30]);
      lg = int'(cfg_word[23:20]);
      if (lg < 5) lg = 5;
      if (lg > 12) lg = 12;
      sz = 1 << lg;
      bb = (int'(cfg_word[17:16]) + 1) * 4096;
      tmo = int'(cfg_word[11:4]);
      hirq = (cfg_word[13:12] == 2'b01);
      rdm = m_rd % sz;
      weff = (int'(wr_index) / 8 * 8) % sz;
      full = (((weff - rdm + sz) % sz) == 0);
      ex = (m_st == 1) && !frm_valid && tick_32us && tmo != 0 && (m_cnt + 1 >= tmo);
      if (m_st != 1 || frm_valid) ncnt = 0;
      else if (tick_32us && !ex)  ncnt = (m_cnt + 1) % 256;
      else                        ncnt = m_cnt;
      e_open = 0; e_pw = 0; e_sw = 0; e_irq = 0; cls = 0; nst = m_st;
      case (m_st)
        0: if (frm_valid) begin
          if (mode == 2 && !full) begin
            e_open = 1; e_pw = 1; e_po = 0; m_off = 4;
            e_desc = longint'(ring_base) * 256 + rdm * 4;
            if (frm_last) cls = 1; else nst = 1;
          end else begin
            if (mode == 2) e_ovf = 1;
            if (!frm_last) nst = 2;
          end
        end
        1: if (mode == 0 || mode == 3) nst = (frm_valid && frm_last) ? 0 : 2;
           else if (frm_valid) begin
             if (m_off < bb) begin e_pw = 1; e_po = m_off; m_off += 4; end
             if (frm_last) begin cls = 1; nst = 0; end
           end else if (ex) begin cls = 1; nst = 2; end
        default: if (frm_valid && frm_last) nst = 0;
      endcase
      if (cls) begin
        e_sw = 1; e_sd = rdm; e_irq = hirq; e_sa = longint'(stat_base) * 16;
        m_rd = (rdm + 1) % sz;
      end
      e_idle = (nst != 1) && (mode != 2);
      m_st = nst; m_cnt = ncnt;
    end
  end

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      check(buf_open == e_open, "R3 buf_open", buf_open, e_open);
      if (e_open) check(buf_desc_addr == e_desc, "R3 buf_desc_addr", buf_desc_addr, e_desc);
      check(pay_wr == e_pw, "R4 pay_wr", pay_wr, e_pw);
      if (e_pw) check(pay_off == e_po, "R4 pay_off", pay_off, e_po);
      check(stat_wr == e_sw, "R6 stat_wr", stat_wr, e_sw);
      if (e_sw) begin
        check(stat_data == e_sd, "R6 stat_data", stat_data, e_sd);
        check(stat_addr == e_sa, "R6 stat_addr", stat_addr, e_sa);
      end
      check(irq == e_irq, "R8 irq", irq, e_irq);
      check(chan_idle == e_idle, "R10 chan_idle", chan_idle, e_idle);
      check(overflow == e_ovf, "R5 overflow", overflow, e_ovf);
      check(rd_index == m_rd, "R2 rd_index", rd_index, m_rd);
    end
  end

  always @(negedge clk) begin
    tcnt = (tcnt + 1) % 4;
    tick_32us = (tcnt == 0);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send_frame(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      frm_valid = 1'b1;
      frm_last = (i == n - 1);
    end
    @(negedge clk);
    frm_valid = 1'b0;
    frm_last = 1'b0;
  endtask

  task automatic send_beats(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      frm_valid = 1'b1;
      frm_last = 1'b0;
    end
    @(negedge clk);
    frm_valid = 1'b0;
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst = 1'b1;
    wait_cyc(3);
    rst = 1'b0;
    wait_cyc(1);
  endtask

  initial begin
    do_reset();
    // R1 reset state
    check(rd_index == 0 && !overflow && chan_idle && !pay_wr && !stat_wr && !irq && !buf_open,
          "R1 reset state", {overflow, chan_idle, rd_index}, 13'h1000);

    // R2 R3 R4 R6: fill a 256-entry ring up to producer index 16
    cfg_word = mk(2, 8, 0, 1, 16);
    wr_index = 12'd16;
    for (int f = 0; f < 16; f++) send_frame(1 + (f % 5) * 3);
    wait_cyc(2);
    check(rd_index == 16, "R2 rd_index after 16 frames", rd_index, 16);
    check(!overflow, "R5 no overflow before full", overflow, 0);
    // R5 full ring drops frame
    send_frame(3);
    wait_cyc(2);
    check(overflow, "R5 overflow on full ring", overflow, 1);
    check(rd_index == 16, "R5 rd_index unchanged when full", rd_index, 16);
    // R5 rounding: 21 rounds down to 16, still full
    wr_index = 12'd21;
    send_frame(2);
    wait_cyc(2);
    check(rd_index == 16, "R5 unaligned producer index rounded", rd_index, 16);

    // R4 truncation with a 4 KiB buffer, then 16 KiB
    wr_index = 12'd0;
    send_frame(1030);
    wait_cyc(2);
    check(rd_index == 17, "R4 oversize frame closed once", rd_index, 17);
    cfg_word = mk(2, 8, 3, 1, 16);
    send_frame(5);
    wait_cyc(2);
    check(rd_index == 18, "R4 16K buffer frame", rd_index, 18);

    // R7 timeout close on a stalled frame
    cfg_word = mk(2, 8, 0, 1, 2);
    send_beats(3);
    wait_cyc(30);
    check(rd_index == 19, "R7 timeout closes buffer", rd_index, 19);
    send_frame(1);
    wait_cyc(2);
    check(rd_index == 19, "R7 rest of timed-out frame discarded", rd_index, 19);

    // R8 no interrupt destination
    cfg_word = mk(2, 8, 0, 0, 0);
    send_frame(4);
    wait_cyc(2);
    check(rd_index == 20, "R8 frame closes without irq", rd_index, 20);

    // R9 stop after current frame
    cfg_word = mk(2, 8, 0, 1, 0);
    send_beats(2);
    cfg_word = mk(1, 8, 0, 1, 0);
    send_frame(2);
    wait_cyc(2);
    check(rd_index == 21, "R9 graceful stop completes frame", rd_index, 21);
    send_frame(3);
    wait_cyc(2);
    check(rd_index == 21, "R11 new frame rejected when stopping", rd_index, 21);
    check(chan_idle, "R10 idle after graceful stop", chan_idle, 1);

    // R9 immediate stop with mode 00 and 11
    cfg_word = mk(2, 8, 0, 1, 0);
    send_beats(2);
    check(!chan_idle, "R10 not idle while filling", chan_idle, 0);
    cfg_word = mk(0, 8, 0, 1, 0);
    wait_cyc(3);
    send_frame(2);
    wait_cyc(2);
    check(rd_index == 21, "R9 abort does not advance", rd_index, 21);
    cfg_word = mk(2, 8, 0, 1, 0);
    send_beats(1);
    cfg_word = mk(3, 8, 0, 1, 0);
    wait_cyc(2);
    send_frame(1);
    wait_cyc(2);
    check(rd_index == 21, "R9 mode 11 aborts", rd_index, 21);
    check(chan_idle, "R10 idle after abort", chan_idle, 1);

    // R11 frames while off after reset; R2 clamped small ring wraps
    do_reset();
    cfg_word = mk(0, 3, 0, 1, 0);
    wr_index = 12'd24;
    send_frame(2);
    send_frame(1);
    wait_cyc(2);
    check(!overflow && rd_index == 0, "R11 off-mode frames dropped quietly", overflow, 0);
    cfg_word = mk(2, 3, 0, 1, 0);
    for (int f = 0; f < 24; f++) send_frame(1 + f % 2);
    wait_cyc(2);
    check(rd_index == 24, "R2 clamped ring fills to 24", rd_index, 24);
    wr_index = 12'd8;
    for (int f = 0; f < 20; f++) send_frame(1);
    wait_cyc(2);
    check(rd_index == 8, "R2 ring wraps at 32 entries", rd_index, 8);
    check(overflow, "R5 overflow after wrap", overflow, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule